// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Servicer

This block sits between a set of interrupt sources and a destination-matching fabric. Each pin has a programmable routing entry. The entry holds a vector, a destination, a destination mode, a delivery mode, a trigger mode and a mask. Source events raise or drop a pin's line. The block keeps a request bit and a remote-IRR bit for every pin. From these it decides when a pin may present a delivery request on the output.

The output is a single delivery channel. A request stays up from a registered state until the cycle it is served. In that same cycle, the fabric answers on `dlv_taken` whether any target accepted it. Level-triggered pins that were accepted stay blocked until a level end-of-interrupt (EOI) with a matching vector arrives. Duplicate edges on an edge-triggered pin are merged. When a level pin is redelivered by EOI too many times in a row, the next redelivery is held back for a programmable number of cycles. After that delay, one sweep services every eligible level pin.

Top module: `irq_pin_servicer`

## Requirements
- R1: After reset every entry is masked, every request and remote-IRR bit is clear, and `dlv_valid` is low.
- R2: A deassert event (`ev_level`=0) clears the pin's request bit and causes no delivery. A later level EOI for that pin therefore redelivers nothing.
- R3: On an edge-mode pin (`cfg_level_trig`=0), an assert event with the request bit clear sets the bit and delivers once. A further assert without an intervening deassert is merged and delivers nothing.
- R4: On a level-mode pin (`cfg_level_trig`=1), an assert event sets the request bit. No delivery is made while the pin's remote-IRR bit is set.
- R5: A pin whose entry has `cfg_mask`=1 is never delivered. Its request bit stays set.
- R6: A level delivery answered with `dlv_taken`=1 sets the pin's remote-IRR bit. One answered with `dlv_taken`=0 leaves it clear.
- R7: A level EOI (`eoi_level`=1) clears remote-IRR on every level-mode pin whose vector equals `eoi_vector`. Each such pin that is unmasked with its request bit set is delivered again. Pins with other vectors are unaffected.
- R8: Each pin counts consecutive EOI-driven redeliveries. The count clears when the pin is masked or idle at an EOI. The EOI that brings the count to `STORM_LIMIT` delivers nothing, zeroes the count, and starts a `DEFER_CYCLES` timer. When the timer expires, every level-mode pin with request set and remote-IRR clear is delivered.
- R9: Rewriting an entry clears its remote-IRR bit. If the new entry is level mode and the request bit is set, the pin is serviced.
- R10: Pins that are ready together are delivered one per cycle, lowest pin index first.
- R11: A delivery carries the served pin's index, vector, destination, destination mode, delivery mode and trigger mode as programmed.
- R12: An edge EOI (`eoi_level`=0) leaves remote-IRR unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Line event strobe |
| ev_pin | input | PIN_W | Pin of the line event |
| ev_level | input | 1 | 1 = line asserted, 0 = line dropped |
| cfg_we | input | 1 | Entry rewrite strobe |
| cfg_pin | input | PIN_W | Pin whose entry is rewritten |
| cfg_vector | input | VEC_W | New vector |
| cfg_dest | input | DEST_W | New destination |
| cfg_dest_logical | input | 1 | New destination mode (1 = logical) |
| cfg_dmode | input | DMODE_W | New delivery mode |
| cfg_level_trig | input | 1 | New trigger mode (1 = level) |
| cfg_mask | input | 1 | New mask bit |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level EOI, 0 = edge EOI |
| dlv_valid | output | 1 | Delivery request present |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_vector | output | VEC_W | Vector of the delivery |
| dlv_dest | output | DEST_W | Destination of the delivery |
| dlv_dest_logical | output | 1 | Destination mode of the delivery |
| dlv_dmode | output | DMODE_W | Delivery mode of the delivery |
| dlv_level_trig | output | 1 | Trigger mode of the delivery |
| dlv_taken | input | 1 | Fabric reply in the delivery cycle: some target accepted |

## Verification
The bench goes after merged edges. A design that failed to merge them would deliver twice for one held line. It drives level pins answered with and without acceptance. If remote-IRR is set on a refused delivery, the pin stalls forever; if it is never set, interrupts repeat. It probes EOIs that should do nothing: edge EOIs, non-matching vectors and idle pins. A wrong design there either unblocks pins early or redelivers a line that has been dropped. Finally, it runs the storm limit to its trip point, where an off-by-one counter or a missing deferral delivers at the wrong cycle. It also runs a shared-vector EOI, where bad arbitration delivers out of pin order or drops a pin.

// File: rtl/irq_pin_servicer.sv
module irq_pin_servicer #(
  parameter int NPINS        = 24,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int DMODE_W      = 3,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 2500000,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [PIN_W-1:0]   ev_pin,
  input  logic               ev_level,
  input  logic               cfg_we,
  input  logic [PIN_W-1:0]   cfg_pin,
  input  logic [VEC_W-1:0]   cfg_vector,
  input  logic [DEST_W-1:0]  cfg_dest,
  input  logic               cfg_dest_logical,
  input  logic [DMODE_W-1:0] cfg_dmode,
  input  logic               cfg_level_trig,
  input  logic               cfg_mask,
  input  logic               eoi_valid,
  input  logic [VEC_W-1:0]   eoi_vector,
  input  logic               eoi_level,
  output logic               dlv_valid,
  output logic [PIN_W-1:0]   dlv_pin,
  output logic [VEC_W-1:0]   dlv_vector,
  output logic [DEST_W-1:0]  dlv_dest,
  output logic               dlv_dest_logical,
  output logic [DMODE_W-1:0] dlv_dmode,
  output logic               dlv_level_trig,
  input  logic               dlv_taken
);
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);
  localparam int TMR_W = $clog2(DEFER_CYCLES + 1);

  logic [VEC_W-1:0]   vec_q   [NPINS];
  logic [DEST_W-1:0]  dst_q   [NPINS];
  logic [DMODE_W-1:0] dmode_q [NPINS];
  logic [CNT_W-1:0]   cnt_q   [NPINS];
  logic [NPINS-1:0]   logical_q, lvl_q, mask_q, irr_q, rirr_q, svc_q;
  logic               tmr_run;
  logic [TMR_W-1:0]   tmr_cnt;

  logic [NPINS-1:0] deliverable, ready, grant, ev_dec, cfg_dec, eoi_hit, trip;
  logic fire, arm;

  assign ev_dec  = NPINS'(ev_valid) << ev_pin;
  assign cfg_dec = NPINS'(cfg_we) << cfg_pin;
  assign deliverable = ~mask_q & (~lvl_q | (irr_q & ~rirr_q));
  assign ready = svc_q & deliverable;
  assign grant = ready & (~ready + NPINS'(1));
  assign dlv_valid = |ready;
  assign fire = tmr_run && (tmr_cnt == '0);
  assign arm  = |trip;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      eoi_hit[p] = eoi_valid && eoi_level && lvl_q[p] && (vec_q[p] == eoi_vector);
      trip[p]    = eoi_hit[p] && !mask_q[p] && irr_q[p] &&
                   (cnt_q[p] == CNT_W'(STORM_LIMIT - 1));
    end
  end

  always_comb begin
    dlv_pin = '0;
    for (int p = 0; p < NPINS; p++)
      if (grant[p]) dlv_pin = PIN_W'(p);
  end

  assign dlv_vector       = vec_q[dlv_pin];
  assign dlv_dest         = dst_q[dlv_pin];
  assign dlv_dest_logical = logical_q[dlv_pin];
  assign dlv_dmode        = dmode_q[dlv_pin];
  assign dlv_level_trig   = lvl_q[dlv_pin];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_run   <= 1'b0;
      tmr_cnt   <= '0;
      logical_q <= '0;
      lvl_q     <= '0;
      mask_q    <= '1;
      irr_q     <= '0;
      rirr_q    <= '0;
      svc_q     <= '0;
      for (int p = 0; p < NPINS; p++) begin
        vec_q[p]   <= '0;
        dst_q[p]   <= '0;
        dmode_q[p] <= '0;
        cnt_q[p]   <= '0;
      end
    end else begin
      if (arm && (!tmr_run || fire)) begin
        tmr_run <= 1'b1;
        tmr_cnt <= TMR_W'(DEFER_CYCLES - 1);
      end else if (tmr_run) begin
        if (fire) tmr_run <= 1'b0;
        else      tmr_cnt <= tmr_cnt - 1'b1;
      end

      for (int p = 0; p < NPINS; p++) begin
        if (svc_q[p] && (!deliverable[p] || grant[p])) svc_q[p] <= 1'b0;
        if (grant[p] && lvl_q[p] && dlv_taken) rirr_q[p] <= 1'b1;

        if (fire && lvl_q[p] && irr_q[p] && !rirr_q[p]) svc_q[p] <= 1'b1;

        if (eoi_hit[p]) begin
          rirr_q[p] <= 1'b0;
          if (!mask_q[p] && irr_q[p]) begin
            if (trip[p]) cnt_q[p] <= '0;
            else begin
              cnt_q[p] <= cnt_q[p] + 1'b1;
              svc_q[p] <= 1'b1;
            end
          end else begin
            cnt_q[p] <= '0;
          end
        end

        if (ev_dec[p]) begin
          if (!ev_level) irr_q[p] <= 1'b0;
          else begin
            irr_q[p] <= 1'b1;
            if (lvl_q[p] ? !rirr_q[p] : !irr_q[p]) svc_q[p] <= 1'b1;
          end
        end

        if (cfg_dec[p]) begin
          vec_q[p]     <= cfg_vector;
          dst_q[p]     <= cfg_dest;
          dmode_q[p]   <= cfg_dmode;
          logical_q[p] <= cfg_dest_logical;
          lvl_q[p]     <= cfg_level_trig;
          mask_q[p]    <= cfg_mask;
          rirr_q[p]    <= 1'b0;
          if (cfg_level_trig && irr_q[p]) svc_q[p] <= 1'b1;
        end
      end
    end
  end

  p_deassert_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_level |=> !irr_q[$past(ev_pin)]);

  p_level_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_taken && dlv_level_trig && !eoi_valid && !cfg_we
    |=> !(dlv_valid && dlv_pin == $past(dlv_pin)));

  p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_mask |=> !(dlv_valid && dlv_pin == $past(cfg_pin)));

  p_accept_sets_rirr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_taken && dlv_level_trig && !eoi_valid && !cfg_we
    |=> rirr_q[$past(dlv_pin)]);

  p_edge_eoi_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && !eoi_level && !cfg_we && !dlv_valid |=> $stable(rirr_q));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] < CNT_W'(STORM_LIMIT));
  end
endmodule

// File: tb/irq_pin_servicer_tb.sv
module irq_pin_servicer_tb;
  localparam int NPINS = 4, VEC_W = 8, DEST_W = 8, DMODE_W = 3;
  localparam int LIMIT = 3, DEFER = 16, PIN_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 0, ev_level = 0, cfg_we = 0, cfg_dest_logical = 0;
  logic cfg_level_trig = 0, cfg_mask = 0, eoi_valid = 0, eoi_level = 0, dlv_taken = 0;
  logic [PIN_W-1:0] ev_pin = '0, cfg_pin = '0;
  logic [VEC_W-1:0] cfg_vector = '0, eoi_vector = '0;
  logic [DEST_W-1:0] cfg_dest = '0;
  logic [DMODE_W-1:0] cfg_dmode = '0;
  logic dlv_valid, dlv_dest_logical, dlv_level_trig;
  logic [PIN_W-1:0] dlv_pin;
  logic [VEC_W-1:0] dlv_vector;
  logic [DEST_W-1:0] dlv_dest;
  logic [DMODE_W-1:0] dlv_dmode;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_pin_servicer #(.NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .DMODE_W(DMODE_W),
    .STORM_LIMIT(LIMIT), .DEFER_CYCLES(DEFER)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pin(ev_pin), .ev_level(ev_level),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
    .cfg_dest_logical(cfg_dest_logical), .cfg_dmode(cfg_dmode),
    .cfg_level_trig(cfg_level_trig), .cfg_mask(cfg_mask), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .eoi_level(eoi_level), .dlv_valid(dlv_valid),
    .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
    .dlv_dest_logical(dlv_dest_logical), .dlv_dmode(dlv_dmode),
    .dlv_level_trig(dlv_level_trig), .dlv_taken(dlv_taken));

  task automatic chk(string req, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ev(int pin, bit lvl);
    ev_valid = 1; ev_pin = PIN_W'(pin); ev_level = lvl;
    @(negedge clk); ev_valid = 0;
  endtask

  task automatic cfg(int pin, int vec, int dst, bit lg, int dm, bit lvl, bit msk);
    cfg_we = 1; cfg_pin = PIN_W'(pin); cfg_vector = VEC_W'(vec); cfg_dest = DEST_W'(dst);
    cfg_dest_logical = lg; cfg_dmode = DMODE_W'(dm); cfg_level_trig = lvl; cfg_mask = msk;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic eoi(int vec, bit lvl);
    eoi_valid = 1; eoi_vector = VEC_W'(vec); eoi_level = lvl;
    @(negedge clk); eoi_valid = 0;
  endtask

  task automatic expect_dlv(string req, int pin, int vec, bit taken);
    chk(req, dlv_valid && dlv_pin == PIN_W'(pin), "delivery pin",
        dlv_valid ? int'(dlv_pin) : -1, pin);
    chk(req, dlv_vector == VEC_W'(vec), "delivery vector", int'(dlv_vector), vec);
    dlv_taken = taken;
    @(negedge clk); dlv_taken = 0;
  endtask

  task automatic expect_quiet(string req, int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (dlv_valid) seen = 1;
      @(negedge clk);
    end
    chk(req, !seen, "unexpected delivery", int'(seen), 0);
  endtask

  task automatic t_reset;
    chk("R1", dlv_valid == 0, "dlv_valid after reset", int'(dlv_valid), 0);
    ev(0, 1);
    expect_quiet("R1", 3);
    ev(0, 0);
  endtask

  task automatic t_edge;
    cfg(1, 'h31, 'h05, 1, 3, 0, 0);
    ev(1, 1);
    chk("R11", dlv_dest == 8'h05 && dlv_dest_logical && dlv_dmode == 3 && !dlv_level_trig,
        "delivery fields", {dlv_dest, 3'b0, dlv_dest_logical, 1'b0, dlv_dmode, 3'b0, dlv_level_trig},
        {8'h05, 3'b0, 1'b1, 1'b0, 3'd3, 3'b0, 1'b0});
    expect_dlv("R3", 1, 'h31, 1);
    ev(1, 1);
    expect_quiet("R3", 3);
    ev(1, 0);
    ev(1, 1);
    expect_dlv("R3", 1, 'h31, 1);
    ev(1, 0);
  endtask

  task automatic t_level;
    cfg(2, 'h42, 'h01, 0, 0, 1, 0);
    ev(2, 1);
    expect_dlv("R6", 2, 'h42, 0);
    ev(2, 1);
    expect_dlv("R6", 2, 'h42, 1);
    ev(2, 1);
    expect_quiet("R4", 3);
  endtask

  task automatic t_eoi;
    eoi('h42, 0);
    expect_quiet("R12", 3);
    eoi('h43, 1);
    expect_quiet("R7", 3);
    eoi('h42, 1);
    expect_dlv("R7", 2, 'h42, 1);
    ev(2, 0);
    expect_quiet("R2", 2);
    eoi('h42, 1);
    expect_quiet("R2", 3);
    ev(2, 1);
    expect_dlv("R7", 2, 'h42, 1);
  endtask

  task automatic t_storm;
    eoi('h42, 1);
    expect_dlv("R8", 2, 'h42, 1);
    eoi('h42, 1);
    expect_dlv("R8", 2, 'h42, 1);
    eoi('h42, 1);
    expect_quiet("R8", DEFER - 2);
    begin
      bit got = 0;
      for (int i = 0; i < 4 && !got; i++) begin
        if (dlv_valid) got = 1;
        else @(negedge clk);
      end
      chk("R8", got, "deferred delivery", int'(got), 1);
    end
    expect_dlv("R8", 2, 'h42, 1);
    eoi('h42, 1);
    expect_dlv("R8", 2, 'h42, 1);
  endtask

  task automatic t_mask;
    cfg(3, 'h53, 'h02, 0, 1, 1, 1);
    ev(3, 1);
    expect_quiet("R5", 3);
    cfg(3, 'h53, 'h02, 0, 1, 1, 0);
    expect_dlv("R9", 3, 'h53, 1);
  endtask

  task automatic t_order;
    cfg(2, 'h77, 'h01, 0, 0, 1, 0);
    expect_dlv("R9", 2, 'h77, 1);
    cfg(3, 'h77, 'h02, 0, 0, 1, 0);
    expect_dlv("R9", 3, 'h77, 1);
    eoi('h77, 1);
    expect_dlv("R10", 2, 'h77, 1);
    expect_dlv("R10", 3, 'h77, 1);
    expect_quiet("R10", 2);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_edge;
    t_level;
    t_eoi;
    t_storm;
    t_mask;
    t_order;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule